// File: doc/BRIEF.md
# Audio FIFO with Threshold DMA Request

This block sits between a memory-mapped DMA data port and a serial audio shifter. It holds two word buffers, one per direction. Playback words arrive from DMA writes and leave through a pop handshake toward the shifter. Capture words arrive through a push handshake from the shifter and leave through DMA reads. Each direction raises its own DMA request line, and each request is steered by a threshold that software programs for that stream.

A threshold value of N-1 asks for bursts of N words. Software sets it to half the period size in bytes, minus one, because every sample is a 16-bit word. The largest usable burst is the readable maximum threshold plus one. The two directions behave differently. The capture request follows the buffered word count. The playback request, once raised, stays high until the buffer is completely full, so the buffer is always topped up at stream start. A pop from an empty playback buffer sets a sticky flag, and so does a push into a full capture buffer. Software clears both flags with a write-one-to-clear strobe.

Each request line comes from a two-state machine with states `REQ_OFF` and `REQ_ON`. The playback machine takes `REQ_OFF -> REQ_ON` when free space exceeds the transmit threshold, and `REQ_ON -> REQ_OFF` when the buffer is full. The capture machine takes `REQ_OFF -> REQ_ON` when the word count exceeds the receive threshold, and `REQ_ON -> REQ_OFF` when the count is at or below it. Every other combination stays in the current state. The depth must be a power of two and defaults to 1024 words of 32 bits.

Top module: `audio_fifo_dma`

## Requirements
- R1: While reset is asserted, both request lines are low, the playback buffer reports no word (`tx_pop_ready`=0), the capture buffer reports room (`rx_push_ready`=1), and both sticky flags are 0.
- R2: Words written on the DMA write port come out of `tx_pop_data` in write order, one per accepted pop. A DMA write while the playback buffer is full is dropped.
- R3: Words pushed by the shifter come out of `rx_rd_data` in push order, one per accepted DMA read. A push while the capture buffer is full is dropped, and a DMA read from an empty capture buffer changes nothing.
- R4: In `REQ_OFF`, the playback request rises one cycle after a clock edge at which free space (DEPTH minus stored words) exceeds the transmit threshold.
- R5: In `REQ_ON`, the playback request stays high, whatever the threshold and the free space, until a clock edge at which the buffer holds DEPTH words. It falls one cycle later.
- R6: The capture request is high in a cycle exactly when, at the previous clock edge, the stored word count exceeded the receive threshold.
- R7: Strobing `tx_thr_we` or `rx_thr_we` loads `thr_wdata` into that direction's threshold. With value N-1, the capture request rises only once N words are buffered. `tx_max_thr` and `rx_max_thr` both read DEPTH-1.
- R8: A pop while `tx_pop_ready` is 0 sets `tx_underflow`. The flag stays set until a cycle with `flag_clr_we`=1 and `flag_clr_mask` bit 0 set.
- R9: A push while `rx_push_ready` is 0 sets `rx_overflow`. It is cleared by `flag_clr_we` with `flag_clr_mask` bit 1 set, and a clear of the other bit leaves it alone. If a set and a clear fall in the same cycle, the set wins.
- R10: `tx_pop_ready` is 1 exactly when the playback buffer holds a word, and `rx_push_ready` is 1 exactly when the capture buffer is not full. Both change in the cycle after the access that changes the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr_en | input | 1 | DMA write strobe into the playback buffer |
| tx_wr_data | input | WIDTH | DMA write word |
| rx_rd_en | input | 1 | DMA read strobe from the capture buffer |
| rx_rd_data | output | WIDTH | Oldest capture word |
| tx_thr_we | input | 1 | Load the transmit threshold |
| rx_thr_we | input | 1 | Load the receive threshold |
| thr_wdata | input | log2(DEPTH) | Threshold value (burst length minus one) |
| tx_max_thr | output | log2(DEPTH) | Largest transmit threshold |
| rx_max_thr | output | log2(DEPTH) | Largest receive threshold |
| tx_dma_req | output | 1 | Playback DMA request |
| rx_dma_req | output | 1 | Capture DMA request |
| tx_pop | input | 1 | Shifter takes a playback word |
| tx_pop_data | output | WIDTH | Oldest playback word |
| tx_pop_ready | output | 1 | A playback word is available |
| rx_push | input | 1 | Shifter delivers a capture word |
| rx_push_data | input | WIDTH | Capture word |
| rx_push_ready | output | 1 | The capture buffer has room |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr_mask | input | 2 | Bit 0 clears underflow, bit 1 clears overflow |
| tx_underflow | output | 1 | Sticky playback underflow |
| rx_overflow | output | 1 | Sticky capture overflow |

## Verification
The hardest case to reach is a playback request held high while free space has dropped to or below the threshold. The stimulus reaches it for every threshold value of a 16-deep configuration by filling the buffer one word per cycle, with one extra dropped write, and then draining it, while a cycle model built from the requirements is compared with every output on every cycle. A second hard case is an overflow set that collides with a clear of the same flag. The stimulus reaches it by filling the capture buffer, then pushing into it in the very cycle the clear strobe is given.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
    typedef enum logic {
        REQ_OFF = 1'b0,
        REQ_ON  = 1'b1
    } req_state_e;
endpackage

// File: rtl/audfifo_buf.sv
module audfifo_buf #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             wr_ok, rd_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) rptr <= rptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2 / R3: occupancy never passes the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: a lone accepted read lowers the occupancy by one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && !wr_en) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/audfifo_reqfsm.sv
module audfifo_reqfsm
    import audfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter bit IS_TX = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] thr,
    output logic          req
);
    req_state_e st, st_nx;
    logic [CW-1:0] thr_w;

    assign thr_w = {1'b0, thr};

    generate
        if (IS_TX) begin : g_tx
            logic [CW-1:0] free_w;
            assign free_w = CW'(DEPTH) - count;
            always_comb begin
                st_nx = st;
                unique case (st)
                    REQ_OFF: if (free_w > thr_w)       st_nx = REQ_ON;
                    REQ_ON:  if (count == CW'(DEPTH))  st_nx = REQ_OFF;
                endcase
            end
        end else begin : g_rx
            always_comb begin
                st_nx = st;
                unique case (st)
                    REQ_OFF: if (count > thr_w)  st_nx = REQ_ON;
                    REQ_ON:  if (count <= thr_w) st_nx = REQ_OFF;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st <= REQ_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        req = (st == REQ_ON);
    end
endmodule

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr_en,
    input  logic [WIDTH-1:0] tx_wr_data,
    input  logic             rx_rd_en,
    output logic [WIDTH-1:0] rx_rd_data,
    input  logic             tx_thr_we,
    input  logic             rx_thr_we,
    input  logic [AW-1:0]    thr_wdata,
    output logic [AW-1:0]    tx_max_thr,
    output logic [AW-1:0]    rx_max_thr,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_pop_data,
    output logic             tx_pop_ready,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_push_data,
    output logic             rx_push_ready,
    input  logic             flag_clr_we,
    input  logic [1:0]       flag_clr_mask,
    output logic             tx_underflow,
    output logic             rx_overflow
);
    logic [AW-1:0] tx_thr, rx_thr;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_free;

    assign tx_max_thr    = AW'(DEPTH - 1);
    assign rx_max_thr    = AW'(DEPTH - 1);
    assign tx_pop_ready  = !tx_empty;
    assign rx_push_ready = !rx_full;
    assign tx_free       = CW'(DEPTH) - tx_count;

    audfifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr_en), .wr_data(tx_wr_data),
        .rd_en(tx_pop), .rd_data(tx_pop_data),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    audfifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_push), .wr_data(rx_push_data),
        .rd_en(rx_rd_en), .rd_data(rx_rd_data),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    audfifo_reqfsm #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txreq (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .thr(tx_thr), .req(tx_dma_req)
    );

    audfifo_reqfsm #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxreq (
        .clk(clk), .rst_n(rst_n), .count(rx_count), .thr(rx_thr), .req(rx_dma_req)
    );

    // threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else begin
            if (tx_thr_we) tx_thr <= thr_wdata;
            if (rx_thr_we) rx_thr <= thr_wdata;
        end
    end

    // sticky flags: a new event beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_underflow <= 1'b0;
            rx_overflow  <= 1'b0;
        end else begin
            if (tx_pop && tx_empty)                         tx_underflow <= 1'b1;
            else if (flag_clr_we && flag_clr_mask[0])       tx_underflow <= 1'b0;
            if (rx_push && rx_full)                         rx_overflow  <= 1'b1;
            else if (flag_clr_we && flag_clr_mask[1])       rx_overflow  <= 1'b0;
        end
    end

    assert_txreq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_dma_req) |-> $past(tx_free > {1'b0, tx_thr}));

    assert_txreq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_dma_req) |-> $past(tx_full));

    assert_rxreq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> $past(rx_count > {1'b0, rx_thr}));

    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !(flag_clr_we && flag_clr_mask[0])) |=> tx_underflow);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !(flag_clr_we && flag_clr_mask[1])) |=> rx_overflow);

    assert_rx_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_empty && !rx_push) |=> (rx_count == '0));
endmodule

// File: tb/tb_audio_fifo_dma.sv
`timescale 1ns/1ps
module tb_audio_fifo_dma;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n;
    logic tx_wr_en, rx_rd_en, tx_thr_we, rx_thr_we, tx_pop, rx_push, flag_clr_we;
    logic [31:0] tx_wr_data, rx_push_data, rx_rd_data, tx_pop_data;
    logic [AW-1:0] thr_wdata, tx_max_thr, rx_max_thr;
    logic [1:0] flag_clr_mask;
    logic tx_dma_req, rx_dma_req, tx_pop_ready, rx_push_ready, tx_underflow, rx_overflow;

    always #10 clk = ~clk;

    audio_fifo_dma #(.WIDTH(32), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_thr_we(tx_thr_we), .rx_thr_we(rx_thr_we), .thr_wdata(thr_wdata),
        .tx_max_thr(tx_max_thr), .rx_max_thr(rx_max_thr),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_pop_ready(tx_pop_ready),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_ready(rx_push_ready),
        .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // cycle model built from the requirements
    int m_txc, m_rxc, m_txthr, m_rxthr;
    bit m_txon, m_rxon, m_uf, m_of;
    logic [31:0] qtx[$];
    logic [31:0] qrx[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txc = 0; m_rxc = 0; m_txthr = 0; m_rxthr = 0;
            m_txon = 0; m_rxon = 0; m_uf = 0; m_of = 0;
            qtx.delete(); qrx.delete();
        end else begin
            bit nt, nr, tw, tp, rw, rr;
            nt = m_txon ? (m_txc != D) : ((D - m_txc) > m_txthr);
            nr = (m_rxc > m_rxthr);
            tw = tx_wr_en && (m_txc < D);
            tp = tx_pop && (m_txc > 0);
            rw = rx_push && (m_rxc < D);
            rr = rx_rd_en && (m_rxc > 0);
            if (tx_pop && m_txc == 0) m_uf = 1;
            else if (flag_clr_we && flag_clr_mask[0]) m_uf = 0;
            if (rx_push && m_rxc == D) m_of = 1;
            else if (flag_clr_we && flag_clr_mask[1]) m_of = 0;
            if (tp) void'(qtx.pop_front());
            if (tw) qtx.push_back(tx_wr_data);
            if (rr) void'(qrx.pop_front());
            if (rw) qrx.push_back(rx_push_data);
            m_txc = qtx.size();
            m_rxc = qrx.size();
            if (tx_thr_we) m_txthr = int'(thr_wdata);
            if (rx_thr_we) m_rxthr = int'(thr_wdata);
            m_txon = nt;
            m_rxon = nr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4/R5 tx_dma_req", 32'(tx_dma_req), 32'(m_txon));
        chk("R6 rx_dma_req", 32'(rx_dma_req), 32'(m_rxon));
        chk("R10 tx_pop_ready", 32'(tx_pop_ready), 32'(m_txc != 0));
        chk("R10 rx_push_ready", 32'(rx_push_ready), 32'(m_rxc != D));
        chk("R8 tx_underflow", 32'(tx_underflow), 32'(m_uf));
        chk("R9 rx_overflow", 32'(rx_overflow), 32'(m_of));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        tx_wr_en = 0; rx_rd_en = 0; tx_thr_we = 0; rx_thr_we = 0;
        tx_pop = 0; rx_push = 0; flag_clr_we = 0; flag_clr_mask = 2'b00;
    endtask

    task automatic peek_data();
        #1;
        if (tx_pop && qtx.size() > 0) chk("R2 tx_pop_data", tx_pop_data, qtx[0]);
        if (rx_rd_en && qrx.size() > 0) chk("R3 rx_rd_data", rx_rd_data, qrx[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        tx_wr_en = 0; rx_rd_en = 0; tx_thr_we = 0; rx_thr_we = 0;
        tx_pop = 0; rx_push = 0; flag_clr_we = 0; flag_clr_mask = 2'b00;
        tx_wr_data = 0; rx_push_data = 0; thr_wdata = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_dma_req", 32'(tx_dma_req), 0);
        chk("R1 rx_dma_req", 32'(rx_dma_req), 0);
        chk("R1 tx_pop_ready", 32'(tx_pop_ready), 0);
        chk("R1 rx_push_ready", 32'(rx_push_ready), 1);
        chk("R1 flags", {30'd0, tx_underflow, rx_overflow}, 0);
        chk("R7 tx_max_thr", 32'(tx_max_thr), D - 1);
        chk("R7 rx_max_thr", 32'(rx_max_thr), D - 1);
        rst_n = 1;
        cyc();
        chk("R4 start request", 32'(tx_dma_req), 1);

        // playback sweep over every threshold
        for (int t = 0; t < D; t++) begin
            tx_thr_we = 1; thr_wdata = AW'(t);
            cyc();
            for (int i = 0; i <= D; i++) begin
                tx_wr_en = 1; tx_wr_data = 32'(t * 256 + i);
                cyc();
                if (i == D - 2) chk("R5 held below threshold", 32'(tx_dma_req), 1);
            end
            cyc();
            chk("R5 drop after full", 32'(tx_dma_req), 0);
            for (int i = 0; i <= D; i++) begin
                tx_pop = 1;
                peek_data();
                cyc();
            end
            chk("R8 underflow set", 32'(tx_underflow), 1);
            flag_clr_we = 1; flag_clr_mask = 2'b10;
            cyc();
            chk("R8 other bit keeps", 32'(tx_underflow), 1);
            flag_clr_we = 1; flag_clr_mask = 2'b01;
            cyc();
            chk("R8 cleared", 32'(tx_underflow), 0);
        end

        // capture sweep over every threshold
        for (int t = 0; t < D; t++) begin
            rx_thr_we = 1; thr_wdata = AW'(t);
            cyc();
            for (int i = 0; i < t; i++) begin
                rx_push = 1; rx_push_data = 32'(32'h1000 + t * 64 + i);
                cyc();
            end
            cyc();
            chk("R7 below burst", 32'(rx_dma_req), 0);
            rx_push = 1; rx_push_data = 32'(32'h2000 + t);
            cyc();
            cyc();
            chk("R7 burst reached", 32'(rx_dma_req), 1);
            for (int i = t + 1; i <= D; i++) begin
                rx_push = 1; rx_push_data = 32'(32'h3000 + t * 64 + i);
                cyc();
            end
            chk("R9 overflow set", 32'(rx_overflow), 1);
            flag_clr_we = 1; flag_clr_mask = 2'b01;
            cyc();
            chk("R9 other bit keeps", 32'(rx_overflow), 1);
            for (int i = 0; i <= D; i++) begin
                rx_rd_en = 1;
                peek_data();
                cyc();
            end
            flag_clr_we = 1; flag_clr_mask = 2'b10;
            cyc();
            chk("R9 cleared", 32'(rx_overflow), 0);
        end

        // set and clear of overflow in the same cycle
        for (int i = 0; i < D; i++) begin
            rx_push = 1; rx_push_data = 32'(i);
            cyc();
        end
        rx_push = 1; flag_clr_we = 1; flag_clr_mask = 2'b10;
        cyc();
        chk("R9 set beats clear", 32'(rx_overflow), 1);
        for (int i = 0; i < D; i++) begin
            rx_rd_en = 1;
            peek_data();
            cyc();
        end

        // mixed traffic on both sides
        tx_thr_we = 1; rx_thr_we = 1; thr_wdata = AW'(5);
        cyc();
        for (int i = 0; i < 200; i++) begin
            tx_wr_en = (i % 3) != 0; tx_wr_data = 32'(32'h5000 + i);
            tx_pop = (i % 2) == 1;
            rx_push = (i % 4) != 1; rx_push_data = 32'(32'h6000 + i);
            rx_rd_en = (i % 5) < 2;
            peek_data();
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule